// File: doc/BRIEF.md
# Byte-Stream Instruction Decoder

This block takes machine code one byte at a time and turns it into one record per instruction. It covers a small 8-bit accumulator instruction subset. Each record gives a mnemonic code, an addressing-mode code, an operand length and the operand value. The first byte after reset is taken as an opcode. The block looks the opcode up to find how many operand bytes follow, which is 0, 1 or 2, and collects those bytes. The byte after the last operand byte is then taken as the next opcode.

Input and output both use a valid/ready handshake. A finished record stays on the output until the consumer takes it, and no input byte is accepted while a record is waiting. An opcode that is not in the table produces a one-byte record with an illegal flag, and decoding goes on from the next byte. The length of an immediate operand depends on the register width: a 16-bit load or add takes two bytes, while 8-bit immediates and direct addresses take one.

Top module: `insn_byte_decoder`

## Requirements
- R1: A synchronous reset clears `out_valid`, raises `in_ready` and drops any partly collected instruction, so the next accepted byte is decoded as an opcode.
- R2: Opcode 0x01 gives a record with mnemonic 0 (no-op), mode 0 (inherent), length 0 and operand 0x0000.
- R3: Opcodes 0x86, 0xC6, 0x8B and 0xCB give mnemonics 1, 2, 4 and 5 (load A, load B, add A, add B), mode 1 (immediate) and length 1. The operand is the following byte, zero-extended to 16 bits.
- R4: Opcodes 0xCC and 0xC3 give mnemonics 3 and 6 (load D, add D), mode 1 and length 2. The operand is the next two bytes, with the first byte in bits 15:8.
- R5: Opcodes 0x96, 0xD6, 0xDC, 0x9B, 0xDB, 0xD3, 0x97, 0xD7 and 0xDD give mode 2 (direct) and length 1, with mnemonics 1, 2, 3, 4, 5, 6, 7, 8 and 9 in that order (7 to 9 are store A, store B, store D). The operand is the zero-extended address byte.
- R6: Any other opcode gives a record with `out_illegal` at 1, mnemonic 15, mode 0, length 0 and operand 0. The next byte is decoded as an opcode.
- R7: While `out_valid` is high and `out_ready` is low, every record field stays stable and `in_ready` stays low.
- R8: A continuous stream produces exactly one record per instruction, in stream order. For example, 96 30 8B 07 97 30 96 31 gives load A direct 0x30, add A immediate 0x07, store A direct 0x30 and load A direct 0x31.
- R9: An operand byte is always taken as data, even when its value equals an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Machine-code byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | Record is valid |
| out_ready | input | 1 | Consumer accepts the record |
| out_op | output | 4 | Mnemonic code |
| out_mode | output | 2 | Addressing mode: 0 inherent, 1 immediate, 2 direct |
| out_len | output | 2 | Number of operand bytes |
| out_operand | output | 16 | Operand value |
| out_illegal | output | 1 | Opcode was not in the table |

## Verification
The hardest case to reach is a reset that arrives while a two-byte immediate is only partly collected. It is easy to confuse with an ordinary stall. The bench sends the 16-bit load opcode and its high byte, asserts reset, and then sends 0x01. The next record must be a no-op; if the partial instruction survived, the 0x01 would be taken as its low operand byte instead. The bench also stalls a record with a byte waiting on the input, which shows that the waiting byte is neither consumed nor merged into the held record.

// File: rtl/insn_byte_decoder.sv
module insn_byte_decoder (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [3:0]  out_op,
  output logic [1:0]  out_mode,
  output logic [1:0]  out_len,
  output logic [15:0] out_operand,
  output logic        out_illegal
);

  localparam logic [1:0] M_INH = 2'd0, M_IMM = 2'd1, M_DIR = 2'd2;

  typedef enum logic [1:0] {S_OPC, S_OP1, S_OP2, S_OUT} st_t;
  st_t st;

  logic [3:0] dec_op;
  logic [1:0] dec_mode, dec_len;
  logic       dec_ill;

  always_comb begin
    dec_op = 4'd15; dec_mode = M_INH; dec_len = 2'd0; dec_ill = 1'b0;
    case (in_byte)
      8'h01: dec_op = 4'd0;
      8'h86: begin dec_op = 4'd1; dec_mode = M_IMM; dec_len = 2'd1; end
      8'hC6: begin dec_op = 4'd2; dec_mode = M_IMM; dec_len = 2'd1; end
      8'h8B: begin dec_op = 4'd4; dec_mode = M_IMM; dec_len = 2'd1; end
      8'hCB: begin dec_op = 4'd5; dec_mode = M_IMM; dec_len = 2'd1; end
      8'hCC: begin dec_op = 4'd3; dec_mode = M_IMM; dec_len = 2'd2; end
      8'hC3: begin dec_op = 4'd6; dec_mode = M_IMM; dec_len = 2'd2; end
      8'h96: begin dec_op = 4'd1; dec_mode = M_DIR; dec_len = 2'd1; end
      8'hD6: begin dec_op = 4'd2; dec_mode = M_DIR; dec_len = 2'd1; end
      8'hDC: begin dec_op = 4'd3; dec_mode = M_DIR; dec_len = 2'd1; end
      8'h9B: begin dec_op = 4'd4; dec_mode = M_DIR; dec_len = 2'd1; end
      8'hDB: begin dec_op = 4'd5; dec_mode = M_DIR; dec_len = 2'd1; end
      8'hD3: begin dec_op = 4'd6; dec_mode = M_DIR; dec_len = 2'd1; end
      8'h97: begin dec_op = 4'd7; dec_mode = M_DIR; dec_len = 2'd1; end
      8'hD7: begin dec_op = 4'd8; dec_mode = M_DIR; dec_len = 2'd1; end
      8'hDD: begin dec_op = 4'd9; dec_mode = M_DIR; dec_len = 2'd1; end
      default: dec_ill = 1'b1;
    endcase
  end

  assign in_ready  = (st != S_OUT);
  assign out_valid = (st == S_OUT);
  wire   take      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_OPC;
      out_op      <= 4'd0;
      out_mode    <= M_INH;
      out_len     <= 2'd0;
      out_operand <= 16'h0000;
      out_illegal <= 1'b0;
    end else begin
      case (st)
        S_OPC: if (take) begin
          out_op      <= dec_op;
          out_mode    <= dec_mode;
          out_len     <= dec_len;
          out_illegal <= dec_ill;
          out_operand <= 16'h0000;
          st          <= (dec_len == 2'd0) ? S_OUT : S_OP1;
        end
        S_OP1: if (take) begin
          if (out_len == 2'd1) begin
            out_operand <= {8'h00, in_byte};
            st          <= S_OUT;
          end else begin
            out_operand[15:8] <= in_byte;
            st                <= S_OP2;
          end
        end
        S_OP2: if (take) begin
          out_operand[7:0] <= in_byte;
          st               <= S_OUT;
        end
        default: if (out_ready) st <= S_OPC;
      endcase
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !out_valid && in_ready);

  a_r7_hold_record: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_mode)
      && $stable(out_len) && $stable(out_operand) && $stable(out_illegal));

  a_r7_stall_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r6_illegal_short: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_len == 2'd0 && out_op == 4'd15);

  a_r4_wide_imm: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_mode == M_IMM && (out_op == 4'd3 || out_op == 4'd6) |-> out_len == 2'd2);

  a_r3_narrow_zero_ext: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == 2'd1 |-> out_operand[15:8] == 8'h00);

endmodule

// File: tb/test_insn_byte_decoder.sv
module test_insn_byte_decoder;
  logic clk = 0, rst = 1, in_valid = 0, out_ready = 0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid, out_illegal;
  logic [3:0] out_op;
  logic [1:0] out_mode, out_len;
  logic [15:0] out_operand;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  insn_byte_decoder i_insn_byte_decoder (.*);

  // {b0, b1, b2, nbytes, op, mode, len, operand, illegal}
  localparam int NV = 27;
  localparam logic [56:0] VEC [NV] = '{
    {8'h01,8'h00,8'h00,4'd1,4'd0,4'd0,4'd0,16'h0000,1'b0},  // R2
    {8'h86,8'h12,8'h00,4'd2,4'd1,4'd1,4'd1,16'h0012,1'b0},  // R3
    {8'hC6,8'hFE,8'h00,4'd2,4'd2,4'd1,4'd1,16'h00FE,1'b0},  // R3
    {8'h8B,8'h07,8'h00,4'd2,4'd4,4'd1,4'd1,16'h0007,1'b0},  // R3
    {8'hCB,8'h80,8'h00,4'd2,4'd5,4'd1,4'd1,16'h0080,1'b0},  // R3
    {8'hCC,8'h12,8'h34,4'd3,4'd3,4'd1,4'd2,16'h1234,1'b0},  // R4
    {8'hC3,8'hAB,8'hCD,4'd3,4'd6,4'd1,4'd2,16'hABCD,1'b0},  // R4
    {8'h96,8'h30,8'h00,4'd2,4'd1,4'd2,4'd1,16'h0030,1'b0},  // R5
    {8'hD6,8'h41,8'h00,4'd2,4'd2,4'd2,4'd1,16'h0041,1'b0},  // R5
    {8'hDC,8'h52,8'h00,4'd2,4'd3,4'd2,4'd1,16'h0052,1'b0},  // R5
    {8'h9B,8'h63,8'h00,4'd2,4'd4,4'd2,4'd1,16'h0063,1'b0},  // R5
    {8'hDB,8'h74,8'h00,4'd2,4'd5,4'd2,4'd1,16'h0074,1'b0},  // R5
    {8'hD3,8'h85,8'h00,4'd2,4'd6,4'd2,4'd1,16'h0085,1'b0},  // R5
    {8'h97,8'h96,8'h00,4'd2,4'd7,4'd2,4'd1,16'h0096,1'b0},  // R5
    {8'hD7,8'hA7,8'h00,4'd2,4'd8,4'd2,4'd1,16'h00A7,1'b0},  // R5
    {8'hDD,8'hFF,8'h00,4'd2,4'd9,4'd2,4'd1,16'h00FF,1'b0},  // R5
    {8'h00,8'h00,8'h00,4'd1,4'd15,4'd0,4'd0,16'h0000,1'b1}, // R6
    {8'hFF,8'h00,8'h00,4'd1,4'd15,4'd0,4'd0,16'h0000,1'b1}, // R6
    {8'h87,8'h00,8'h00,4'd1,4'd15,4'd0,4'd0,16'h0000,1'b1}, // R6
    {8'h86,8'h01,8'h00,4'd2,4'd1,4'd1,4'd1,16'h0001,1'b0},  // R9
    {8'hCC,8'h01,8'h86,4'd3,4'd3,4'd1,4'd2,16'h0186,1'b0},  // R9
    {8'hDD,8'hCC,8'h00,4'd2,4'd9,4'd2,4'd1,16'h00CC,1'b0},  // R9
    {8'h96,8'h30,8'h00,4'd2,4'd1,4'd2,4'd1,16'h0030,1'b0},  // R8 stream
    {8'h8B,8'h07,8'h00,4'd2,4'd4,4'd1,4'd1,16'h0007,1'b0},  // R8
    {8'h97,8'h30,8'h00,4'd2,4'd7,4'd2,4'd1,16'h0030,1'b0},  // R8
    {8'h96,8'h31,8'h00,4'd2,4'd1,4'd2,4'd1,16'h0031,1'b0},  // R8
    {8'hC3,8'h00,8'h00,4'd3,4'd6,4'd1,4'd2,16'h0000,1'b0}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic expect_rec(input string req, input logic [3:0] op, input logic [1:0] md,
                            input logic [1:0] ln, input logic [15:0] opd, input logic ill);
    while (!out_valid) @(negedge clk);
    check(req, {out_illegal, out_len, out_mode, out_op, out_operand},
               {ill, ln, md, op, opd});
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset in_ready", in_ready, 1);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      v = VEC[i];
      send(v[56:49]);
      if (v[32:29] > 1) send(v[48:41]);
      if (v[32:29] > 2) send(v[40:33]);
      expect_rec($sformatf("R2-R9 table vector %0d", i), v[28:25], v[22:21], v[18:17], v[16:1], v[0]);
    end

    // R1: reset in the middle of a 16-bit immediate
    send(8'hCC);
    send(8'h12);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 no record after reset", out_valid, 0);
    send(8'h01);
    expect_rec("R1 partial dropped", 4'd0, 2'd0, 2'd0, 16'h0000, 1'b0);

    // R7: record held while stalled, waiting byte not consumed
    send(8'h86);
    @(negedge clk); in_valid = 1; in_byte = 8'h55;
    @(negedge clk);
    check("R7 valid while stalled", out_valid, 1);
    check("R7 in_ready low", in_ready, 0);
    repeat (3) @(negedge clk);
    check("R7 record stable", {out_op, out_mode, out_len, out_operand}, {4'd1, 2'd1, 2'd1, 16'h0055});
    // byte 55 was the operand; now present an opcode while the record waits
    in_byte = 8'h01;
    repeat (2) @(negedge clk);
    check("R7 operand unchanged", out_operand, 16'h0055);
    out_ready = 1; @(negedge clk); out_ready = 0;
    @(negedge clk); in_valid = 0;
    expect_rec("R7 waiting byte decoded after accept", 4'd0, 2'd0, 2'd0, 16'h0000, 1'b0);
    check("R7 no extra record", out_valid, 0);

    // R6: illegal followed directly by a real opcode
    send(8'h42);
    expect_rec("R6 illegal", 4'd15, 2'd0, 2'd0, 16'h0000, 1'b1);
    send(8'h86);
    send(8'h05);
    expect_rec("R6 resume", 4'd1, 2'd1, 2'd1, 16'h0005, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule